// File: doc/BRIEF.md
# Interrupt control coprocessor

This block is a small system-control coprocessor that sits beside a processor core. It keeps the interrupt configuration, shows which interrupt request is pending and holds the address where execution resumes after an interrupt. Each cycle it decides whether the one timer interrupt is taken. The decision depends on the live timer request, the timer's mask bit, a global enable and a hardware-only exception-level flag. That flag blocks nested interrupts until the handler ends with an exception-return strobe.

Software reaches the block through a 5-bit register number. A move-to-coprocessor strobe writes the selected register. The read path is combinational and always reflects the selected register. The core supplies its normal next PC every cycle. When an interrupt is taken, the block saves that PC in the return-address register and raises a taken flag in the same cycle. The core then redirects fetch, and later resumes from the saved return address.

Top module: `irq_cop`

## Requirements
- R1: After a cycle with `rst_n` low, the status word reads 0x00000000, `ret_addr` is 0 and `irq_taken` stays 0 even with `timer_req` high.
- R2: `rdata` shows the status word when `reg_sel` is 12, the cause word when it is 13 and the return address when it is 14. Every other register number reads 0.
- R3: A write strobe with `reg_sel` = 12 loads status bits 15:8 (the interrupt mask) and bit 0 (global enable) from `wdata`. Status bit 1 and bits 31:16 and 7:2 are not changed by the write; bits 31:16 and 7:2 always read 0.
- R4: Only register numbers 12 and 14 are writable. A strobe with any other number, or `wdata` without the strobe, leaves status and return address unchanged.
- R5: The cause word is not stored. Its bit 15 equals `timer_req` in the same cycle, and all its other bits are 0.
- R6: `irq_taken` is high in a cycle exactly when `timer_req`, status bit 15, status bit 0 are all 1 and status bit 1 is 0.
- R7: In the cycle after a taken interrupt, status bit 1 reads 1 and `ret_addr` equals the previous cycle's `next_pc` with bits 1:0 forced to 0.
- R8: An `eret` strobe clears status bit 1 at the next edge, and it wins over an interrupt taken in the same cycle.
- R9: A write strobe with `reg_sel` = 14 loads `wdata` bits 31:2 into the return address. Bits 1:0 always read 0.
- R10: When an interrupt is taken in the same cycle as a software write to register 14, the return address loads `next_pc`, not `wdata`.
- R11: `ret_addr` always shows the stored return address, whatever the value of `reg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 5 | Coprocessor register number for read and write |
| wdata | input | 32 | Data for a coprocessor register write |
| mtc_we | input | 1 | Move-to-coprocessor write strobe |
| eret | input | 1 | Exception-return strobe |
| next_pc | input | 32 | The core's normal next PC |
| timer_req | input | 1 | Live timer interrupt request |
| rdata | output | 32 | Value of the selected register |
| ret_addr | output | 32 | Stored return address |
| irq_taken | output | 1 | An interrupt is taken this cycle |

## Verification
The taken decision is tried with each gating term missing in turn (mask clear, enable clear, exception level set, request low) and then with all terms present. This shows that every term is needed and that none alone is enough. Return-address loading is tried with a software write alone, with an interrupt alone and with both in one cycle, which sets the priority between them. A sweep of all 32 register numbers, an all-ones status write, and strobes to unwritable numbers separate real state from bits that are only wired to zero or ignored.

// File: rtl/cop_pkg.sv
// Package: shared constants and the status field type for the interrupt
// control coprocessor. Assumes a 32-bit word and a 5-bit register number.
package cop_pkg;
    localparam int DATA_W     = 32;
    localparam int REGNUM_W   = 5;
    localparam int REG_STATUS = 12;
    localparam int REG_CAUSE  = 13;
    localparam int REG_EPC    = 14;
    localparam int MASK_LO    = 8;
    localparam int MASK_HI    = 15;
    localparam int MASK_W     = MASK_HI - MASK_LO + 1;
    localparam int LINE_TIMER = 15;
    localparam int TIMER_MIDX = LINE_TIMER - MASK_LO;
    localparam int BIT_IE     = 0;
    localparam int BIT_EXL    = 1;
    localparam int EPC_LSB    = 2;
    localparam int EPC_W      = DATA_W - EPC_LSB;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              ie;
        logic              exl;
    } stat_t;
endpackage

// File: rtl/cop_status.sv
// Module: status storage. Keeps the software-writable fields (mask, global
// enable) in one register and the hardware-only exception level in a
// separate flop. Assumes wr_en_i is already decoded for the status number.
module cop_status
    import cop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [MASK_W-1:0] wr_mask_i,
    input  logic              wr_ie_i,
    input  logic              take_i,
    input  logic              eret_i,
    output stat_t             stat_o
);
    logic [MASK_W-1:0] mask_q;
    logic              ie_q;
    logic              exl_q;

    // Software-writable fields: load on a decoded status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ie_q   <= 1'b0;
        end else if (wr_en_i) begin
            mask_q <= wr_mask_i;
            ie_q   <= wr_ie_i;
        end
    end

    // Exception level: set by a taken interrupt, cleared by return (which wins).
    always_ff @(posedge clk) begin
        if (!rst_n)
            exl_q <= 1'b0;
        else if (eret_i)
            exl_q <= 1'b0;
        else if (take_i)
            exl_q <= 1'b1;
    end

    assign stat_o = '{mask: mask_q, ie: ie_q, exl: exl_q};

    AST_EXL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !eret_i) |=> exl_q); // R7
    AST_EXL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        eret_i |=> !exl_q); // R8
    AST_USER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(mask_q) && $stable(ie_q))); // R4
endmodule

// File: rtl/cop_epc.sv
// Module: return-address register. Stores only the word-aligned upper bits.
// Loads next_pc on a taken interrupt, otherwise write data on a software
// write. Assumes sw_we_i is already decoded for the return-address number.
module cop_epc
    import cop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we_i,
    input  logic              take_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] next_pc_i,
    output logic [DATA_W-1:0] epc_o
);
    logic [EPC_W-1:0] epc_q;
    logic [EPC_W-1:0] epc_d;
    logic             epc_en;
    logic             unused_low;

    // Source select: the hardware load wins over a software write.
    always_comb begin
        epc_en = sw_we_i | take_i;
        epc_d  = take_i ? next_pc_i[DATA_W-1:EPC_LSB] : wdata_i[DATA_W-1:EPC_LSB];
    end

    // Storage of the upper address bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            epc_q <= '0;
        else if (epc_en)
            epc_q <= epc_d;
    end

    assign unused_low = ^{next_pc_i[EPC_LSB-1:0], wdata_i[EPC_LSB-1:0]};
    assign epc_o      = {epc_q, {EPC_LSB{1'b0}}};

    AST_EPC_HW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (epc_q == $past(next_pc_i[DATA_W-1:EPC_LSB]))); // R10
    AST_EPC_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we_i && !take_i) |=> (epc_q == $past(wdata_i[DATA_W-1:EPC_LSB]))); // R9
    AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we_i && !take_i) |=> $stable(epc_q)); // R4
endmodule

// File: rtl/cop_readmux.sv
// Module: read path. Builds the status and cause words from their fields
// and selects one by register number. Purely combinational; unmapped
// numbers return zero.
module cop_readmux
    import cop_pkg::*;
(
    input  logic [REGNUM_W-1:0] reg_sel_i,
    input  stat_t               stat_i,
    input  logic                timer_req_i,
    input  logic [DATA_W-1:0]   epc_i,
    output logic [DATA_W-1:0]   rdata_o
);
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] cause_word;

    // Word assembly: one generated slice per bit position.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bits
        if (b >= MASK_LO && b <= MASK_HI) begin : g_mask
            assign status_word[b] = stat_i.mask[b-MASK_LO];
        end else if (b == BIT_IE) begin : g_ie
            assign status_word[b] = stat_i.ie;
        end else if (b == BIT_EXL) begin : g_exl
            assign status_word[b] = stat_i.exl;
        end else begin : g_zero
            assign status_word[b] = 1'b0;
        end
        if (b == LINE_TIMER) begin : g_line
            assign cause_word[b] = timer_req_i;
        end else begin : g_nline
            assign cause_word[b] = 1'b0;
        end
    end

    // Register select.
    always_comb begin
        case (int'(reg_sel_i))
            REG_STATUS: rdata_o = status_word;
            REG_CAUSE:  rdata_o = cause_word;
            REG_EPC:    rdata_o = epc_i;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_cop.sv
// Module: interrupt control coprocessor top. Decodes software writes,
// forms the taken-interrupt decision and connects status storage, the
// return-address register and the read path. Assumes the strobes are
// single-cycle and the reset is synchronous, active low.
module irq_cop
    import cop_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REGNUM_W-1:0] reg_sel,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                mtc_we,
    input  logic                eret,
    input  logic [DATA_W-1:0]   next_pc,
    input  logic                timer_req,
    output logic [DATA_W-1:0]   rdata,
    output logic [DATA_W-1:0]   ret_addr,
    output logic                irq_taken
);
    stat_t stat;
    logic  wr_status;
    logic  wr_epc;
    logic  take;

    // Write decode: only the status and return-address numbers are writable.
    always_comb begin
        wr_status = mtc_we && (int'(reg_sel) == REG_STATUS);
        wr_epc    = mtc_we && (int'(reg_sel) == REG_EPC);
    end

    // Taken decision: request, its mask bit, global enable, not nested.
    always_comb begin
        take = timer_req && stat.mask[TIMER_MIDX] && stat.ie && !stat.exl;
    end

    cop_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_status),
        .wr_mask_i (wdata[MASK_HI:MASK_LO]),
        .wr_ie_i   (wdata[BIT_IE]),
        .take_i    (take),
        .eret_i    (eret),
        .stat_o    (stat)
    );

    cop_epc u_epc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_we_i   (wr_epc),
        .take_i    (take),
        .wdata_i   (wdata),
        .next_pc_i (next_pc),
        .epc_o     (ret_addr)
    );

    cop_readmux u_rd (
        .reg_sel_i   (reg_sel),
        .stat_i      (stat),
        .timer_req_i (timer_req),
        .epc_i       (ret_addr),
        .rdata_o     (rdata)
    );

    assign irq_taken = take;

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> (!irq_taken || $past(eret))); // R6
    AST_TAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> timer_req); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_sel) < REG_STATUS || int'(reg_sel) > REG_EPC) |-> (rdata == '0)); // R2
    AST_CAUSE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_sel) == REG_CAUSE) |-> (rdata == (DATA_W'(timer_req) << LINE_TIMER))); // R5
    AST_RET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ret_addr[EPC_LSB-1:0] == '0); // R9
endmodule

// File: tb/irq_cop_tb.sv
// Bench: behavioural reference model of the coprocessor, compared with
// the outputs in every cycle before the clock edge.
module irq_cop_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_sel = '0;
    logic [31:0] wdata = '0;
    logic        mtc_we = 1'b0;
    logic        eret = 1'b0;
    logic [31:0] next_pc = '0;
    logic        timer_req = 1'b0;
    logic [31:0] rdata;
    logic [31:0] ret_addr;
    logic        irq_taken;

    int n_run = 0;
    int n_fail = 0;

    // reference model state
    int unsigned m_mask = 0;
    bit          m_ie = 0;
    bit          m_exl = 0;
    int unsigned m_epc = 0;

    irq_cop dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wdata(wdata),
        .mtc_we(mtc_we), .eret(eret), .next_pc(next_pc),
        .timer_req(timer_req), .rdata(rdata), .ret_addr(ret_addr),
        .irq_taken(irq_taken)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input int rs, input bit tr);
        case (rs)
            12: return (m_mask << 8) | (int'(m_exl) << 1) | int'(m_ie);
            13: return tr ? 32'h0000_8000 : 32'h0;
            14: return m_epc;
            default: return 32'h0;
        endcase
    endfunction

    // One cycle: drive inputs, compare outputs, clock, advance the model.
    task automatic cyc(input string tag, input int rs, input logic [31:0] wd,
                       input bit mw, input bit er, input logic [31:0] np,
                       input bit tr);
        bit take;
        reg_sel = rs[4:0]; wdata = wd; mtc_we = mw; eret = er;
        next_pc = np; timer_req = tr;
        #1;
        take = tr && m_mask[7] && m_ie && !m_exl;
        check(tag, "rdata", rdata, model_read(rs, tr));
        check(tag, "ret_addr", ret_addr, m_epc);
        check(tag, "irq_taken", {31'b0, irq_taken}, {31'b0, take});
        @(posedge clk);
        if (mw && rs == 12) begin m_mask = wd[15:8]; m_ie = wd[0]; end
        if (take) m_epc = np & 32'hFFFF_FFFC;
        else if (mw && rs == 14) m_epc = wd & 32'hFFFF_FFFC;
        if (er) m_exl = 0;
        else if (take) m_exl = 1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mtc_we = 0; eret = 0;
        @(posedge clk); @(posedge clk);
        m_mask = 0; m_ie = 0; m_exl = 0; m_epc = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        do_reset();
        // R1: reset state, request high must not be taken
        cyc("R1", 12, 0, 0, 0, 32'h100, 1);
        cyc("R1", 14, 0, 0, 0, 32'h100, 1);
        // R2: sweep every register number
        for (int r = 0; r < 32; r++) cyc("R2", r, 0, 0, 0, 0, r[0]);
        // R5: cause follows live request
        cyc("R5", 13, 0, 0, 0, 0, 1);
        cyc("R5", 13, 0, 0, 0, 0, 0);
        cyc("R5", 13, 0, 0, 0, 0, 1);
        // R3: all-ones write keeps only mask and enable
        cyc("R3", 12, 32'hFFFF_FFFF, 1, 0, 0, 0);
        cyc("R3", 12, 0, 0, 0, 0, 0);
        cyc("R3", 12, 32'h0000_5A00, 1, 0, 0, 0);
        cyc("R3", 12, 0, 0, 0, 0, 0);
        // R4: unwritable numbers and data without strobe change nothing
        cyc("R4", 13, 32'hFFFF_FFFF, 1, 0, 0, 0);
        cyc("R4", 3,  32'hFFFF_FFFF, 1, 0, 0, 0);
        cyc("R4", 12, 32'hFFFF_FFFF, 0, 0, 0, 0);
        cyc("R4", 14, 32'hFFFF_FFFF, 0, 0, 0, 0);
        cyc("R4", 12, 0, 0, 0, 0, 0);
        cyc("R4", 14, 0, 0, 0, 0, 0);
        // R9: software write to return address, low bits dropped
        cyc("R9", 14, 32'h1234_5677, 1, 0, 0, 0);
        cyc("R9", 14, 0, 0, 0, 0, 0);
        // R11: return address visible with other numbers selected
        cyc("R11", 0, 0, 0, 0, 0, 0);
        cyc("R11", 31, 0, 0, 0, 0, 0);
        // R6: each gating term missing in turn
        cyc("R6", 12, 32'h0000_8000, 1, 0, 0, 1);   // mask only
        cyc("R6", 12, 0, 0, 0, 0, 1);
        cyc("R6", 12, 32'h0000_0001, 1, 0, 0, 1);   // enable only
        cyc("R6", 12, 0, 0, 0, 0, 1);
        cyc("R6", 12, 32'h0000_7F01, 1, 0, 0, 1);   // other mask bits
        cyc("R6", 12, 32'h0000_8001, 1, 0, 0, 0);   // all set, no request
        // R7: take with request
        cyc("R7", 12, 0, 0, 0, 32'h0040_0123, 1);
        cyc("R7", 12, 0, 0, 0, 32'h0040_0200, 1);   // nested blocked
        cyc("R7", 14, 0, 0, 0, 32'h0040_0300, 1);
        // R8: return clears level, then a new take
        cyc("R8", 12, 0, 0, 1, 0, 0);
        cyc("R8", 12, 0, 0, 0, 32'h0000_0AAC, 1);
        cyc("R8", 14, 0, 0, 0, 0, 0);
        cyc("R8", 12, 0, 0, 1, 0, 0);
        // R8: return in the same cycle as a take keeps level clear
        cyc("R8", 12, 0, 0, 1, 32'h0000_1000, 1);
        cyc("R8", 12, 0, 0, 0, 32'h0000_2000, 1);
        cyc("R8", 14, 0, 0, 1, 0, 0);
        // R10: take and software write to 14 together
        cyc("R10", 14, 32'hDEAD_BEEC, 1, 0, 32'h0BAD_F00D, 1);
        cyc("R10", 14, 0, 0, 0, 0, 0);
        // R1: reset again mid-run
        do_reset();
        cyc("R1", 12, 0, 0, 0, 0, 1);
        cyc("R1", 14, 0, 0, 0, 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule